// File: doc/BRIEF.md
# Calendar Timekeeper with Guarded Update Cycle

This block keeps the wall-clock time and the calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Once per second it runs an update cycle that moves the whole set forward by one second. The update carries from seconds through to the year, and it uses the length of each month and a divisible-by-four leap rule. Software reaches the values over a small byte-wide register bus.

A status flag warns software that an update is coming. It rises a fixed number of window strobes before the counters move, and it stays high until the end of a settling window after the move. Software should only trust values read while the flag is low. Bus writes to the time registers are dropped while the flag is high. A hold bit in the control register stops new updates from starting, so software can load a new time without a race. The values can be shown and written as packed BCD or as plain binary, and the hours as 24-hour or as 12-hour with a PM bit. The block stores the time in binary internally and converts at the bus, so a change of format takes effect at once on every field.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0; day of week, day of month and month read 1; the control register (address 11) reads 0x02; the status register (address 10) reads 0x00.
- R2: A one-cycle `sec_tick` seen while idle with the hold bit clear sets status bit 7 (address 10) in the next cycle. The counters change one cycle after the LEAD_STROBES-th `win_strobe` counted from that point. The flag then stays high until the cycle after the TAIL_STROBES-th strobe that follows the change. Ticks that arrive during an update are dropped.
- R3: `upd_done` is high for exactly one cycle per update: the first cycle in which the new time can be read.
- R4: Bit 7 of the control register (hold) stops any update from starting while it is 1. Ticks seen then are lost.
- R5: An update adds one second. Seconds wrap 59 to 0 and carry into minutes. Minutes wrap 59 to 0 and carry into hours. Hours wrap 23 to 0 and carry into the day.
- R6: Day of month wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except February. February wraps after 29 when year mod 4 is 0 and after 28 otherwise. The wrap carries into the month.
- R7: Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0.
- R8: Control bit 2 set to 1 selects plain binary for every time and date byte that is read or written. When it is 0, each byte is packed BCD (tens in bits 7:4, units in bits 3:0).
- R9: Control bit 1 set to 1 selects 24-hour hours (0 to 23). When it is 0, hours read and write as 1 to 12, with bit 7 set for PM: 12 AM means hour 0 and 12 PM means hour 12.
- R10: Bus writes to addresses 0, 2, 4, 6, 7, 8 and 9 are ignored while the status flag is high. Writes to addresses 10 and 13 are always ignored.
- R11: Address 13 reads 0x80 (time valid). Bits 6:0 of address 10 read 0. Addresses 1, 3, 5, 12, 14 and 15 read 0.
- R12: Day of week advances with each day carry and wraps from 7 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second that asks for an update |
| win_strobe | input | 1 | Timing strobe that paces the lead and settling windows |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr`, combinational |
| upd_done | output | 1 | One-cycle pulse once the new time is visible |

## Verification
Reads are combinational from registers, so a write or an update shows up on `bus_rdata` in the cycle after the edge that took it. The status flag follows the accepted tick by one cycle, and the time moves in the cycle after the last lead strobe, together with `upd_done`. A behavioural model in the bench steps on the same clock edge from the same inputs, and at every falling edge the bench compares the read byte for the current address and `upd_done` against it, so each of these latencies is checked in the exact cycle it is due. Directed reads with literal values then confirm the calendar corners, the formats and the ignored writes once each update has settled.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_HR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_DOW  = 4'd6;
  localparam logic [ADDR_W-1:0] A_DOM  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON  = 4'd8;
  localparam logic [ADDR_W-1:0] A_YR   = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd10;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd11;
  localparam logic [ADDR_W-1:0] A_VLD  = 4'd13;

  localparam int CB_HOLD = 7;
  localparam int CB_BIN  = 2;
  localparam int CB_H24  = 1;
  localparam logic [DATA_W-1:0] CTRL_RST = 8'h02;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HR, F_DOW, F_DOM, F_MON, F_YR
  } field_e;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] dom;
    logic [2:0] dow;
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{yr: 7'd0, mon: 4'd1, dom: 5'd1, dow: 3'd1,
                                     hr: 5'd0, mn: 6'd0, sec: 6'd0};

  function automatic logic is_leap(input logic [6:0] yr);
    return (yr[1:0] == 2'b00);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
    logic [4:0] len;
    case (mon)
      4'd2: len = is_leap(yr) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: len = 5'd30;
      default: len = 5'd31;
    endcase
    return len;
  endfunction

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] d);
    return {3'b000, d[7:4]} * 7'd10 + {3'b000, d[3:0]};
  endfunction

  function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_field(input logic [7:0] d, input logic bin);
    return bin ? d[6:0] : from_bcd(d);
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] hr, input logic bin,
                                          input logic h24);
    logic [4:0] h12;
    logic [7:0] r;
    if (h24) begin
      r = enc_field({2'b00, hr}, bin);
    end else begin
      if (hr == 5'd0)       h12 = 5'd12;
      else if (hr > 5'd12)  h12 = hr - 5'd12;
      else                  h12 = hr;
      r = enc_field({2'b00, h12}, bin);
      r[7] = (hr >= 5'd12);
    end
    return r;
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] d, input logic bin,
                                          input logic h24);
    logic [6:0] v;
    logic [6:0] base;
    if (h24) begin
      v = dec_field(d, bin);
      base = v;
    end else begin
      v = dec_field({1'b0, d[6:0]}, bin);
      base = (v == 7'd12) ? 7'd0 : v;
      if (d[7]) base = base + 7'd12;
    end
    return base[4:0];
  endfunction

  function automatic rtc_time_t next_time(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec < 6'd59) n.sec = t.sec + 6'd1;
    else begin
      n.sec = 6'd0;
      if (t.mn < 6'd59) n.mn = t.mn + 6'd1;
      else begin
        n.mn = 6'd0;
        if (t.hr < 5'd23) n.hr = t.hr + 5'd1;
        else begin
          n.hr  = 5'd0;
          n.dow = (t.dow >= 3'd7) ? 3'd1 : t.dow + 3'd1;
          if (t.dom < month_len(t.mon, t.yr)) n.dom = t.dom + 5'd1;
          else begin
            n.dom = 5'd1;
            if (t.mon < 4'd12) n.mon = t.mon + 4'd1;
            else begin
              n.mon = 4'd1;
              n.yr  = (t.yr >= 7'd99) ? 7'd0 : t.yr + 7'd1;
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int LEAD_STROBES = 2,
  parameter int TAIL_STROBES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic win_strobe,
  input  logic hold,
  output logic busy,
  output logic commit,
  output logic done
);
  localparam int MAXS = (LEAD_STROBES > TAIL_STROBES) ? LEAD_STROBES : TAIL_STROBES;
  localparam int CW   = $clog2(MAXS + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_STROBES - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_STROBES - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_COMMIT, S_TAIL} st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      S_IDLE: begin
        if (sec_tick && !hold) begin
          st_d  = S_LEAD;
          cnt_d = '0;
        end
      end
      S_LEAD: begin
        if (win_strobe) begin
          if (cnt_q == LEAD_LAST) st_d = S_COMMIT;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      S_COMMIT: begin
        st_d  = S_TAIL;
        cnt_d = '0;
      end
      default: begin
        if (win_strobe) begin
          if (cnt_q == TAIL_LAST) st_d = S_IDLE;
          else cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= (st_q == S_COMMIT);
    end
  end

  assign busy   = (st_q != S_IDLE);
  assign commit = (st_q == S_COMMIT);
  assign done   = done_q;

endmodule

// File: rtl/rtc_time_store.sv
module rtc_time_store
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic       wr_en,
  input  field_e     wr_field,
  input  logic [6:0] wr_val,
  output rtc_time_t  time_q
);
  rtc_time_t t_q;
  rtc_time_t t_inc;

  assign t_inc = next_time(t_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= TIME_RST;
    end else if (commit) begin
      t_q <= t_inc;
    end else if (wr_en) begin
      case (wr_field)
        F_SEC:   t_q.sec <= wr_val[5:0];
        F_MIN:   t_q.mn  <= wr_val[5:0];
        F_HR:    t_q.hr  <= wr_val[4:0];
        F_DOW:   t_q.dow <= wr_val[2:0];
        F_DOM:   t_q.dom <= wr_val[4:0];
        F_MON:   t_q.mon <= wr_val[3:0];
        default: t_q.yr  <= wr_val;
      endcase
    end
  end

  assign time_q = t_q;

endmodule

// File: rtl/rtc_host_port.sv
module rtc_host_port
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  rtc_time_t         time_q,
  output logic              hold,
  output logic              time_wr,
  output field_e            wr_field,
  output logic [6:0]        wr_val
);
  logic [DATA_W-1:0] ctrl_q;
  logic              m_bin, m_h24;
  logic              is_time;

  assign hold  = ctrl_q[CB_HOLD];
  assign m_bin = ctrl_q[CB_BIN];
  assign m_h24 = ctrl_q[CB_H24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= CTRL_RST;
    else if (bus_we && bus_addr == A_CTRL) ctrl_q <= bus_wdata;
  end

  always_comb begin
    is_time  = 1'b1;
    wr_field = F_SEC;
    wr_val   = dec_field(bus_wdata, m_bin);
    case (bus_addr)
      A_SEC: wr_field = F_SEC;
      A_MIN: wr_field = F_MIN;
      A_HR: begin
        wr_field = F_HR;
        wr_val   = {2'b00, dec_hour(bus_wdata, m_bin, m_h24)};
      end
      A_DOW: wr_field = F_DOW;
      A_DOM: wr_field = F_DOM;
      A_MON: wr_field = F_MON;
      A_YR:  wr_field = F_YR;
      default: is_time = 1'b0;
    endcase
  end

  assign time_wr = bus_we && is_time && !busy;

  always_comb begin
    case (bus_addr)
      A_SEC:   bus_rdata = enc_field({1'b0, time_q.sec}, m_bin);
      A_MIN:   bus_rdata = enc_field({1'b0, time_q.mn}, m_bin);
      A_HR:    bus_rdata = enc_hour(time_q.hr, m_bin, m_h24);
      A_DOW:   bus_rdata = enc_field({4'b0, time_q.dow}, m_bin);
      A_DOM:   bus_rdata = enc_field({2'b0, time_q.dom}, m_bin);
      A_MON:   bus_rdata = enc_field({3'b0, time_q.mon}, m_bin);
      A_YR:    bus_rdata = enc_field(time_q.yr, m_bin);
      A_STAT:  bus_rdata = {busy, 7'b0};
      A_CTRL:  bus_rdata = ctrl_q;
      A_VLD:   bus_rdata = 8'h80;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int LEAD_STROBES = 2,
  parameter int TAIL_STROBES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       win_strobe,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       upd_done
);
  import rtc_pkg::*;

  logic       set_hold;
  logic       upd_busy;
  logic       upd_commit;
  logic       time_wr;
  field_e     wr_field;
  logic [6:0] wr_val;
  rtc_time_t  time_q;

  rtc_update_seq #(
    .LEAD_STROBES(LEAD_STROBES),
    .TAIL_STROBES(TAIL_STROBES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .win_strobe(win_strobe),
    .hold      (set_hold),
    .busy      (upd_busy),
    .commit    (upd_commit),
    .done      (upd_done)
  );

  rtc_time_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (upd_commit),
    .wr_en   (time_wr),
    .wr_field(wr_field),
    .wr_val  (wr_val),
    .time_q  (time_q)
  );

  rtc_host_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (upd_busy),
    .time_q   (time_q),
    .hold     (set_hold),
    .time_wr  (time_wr),
    .wr_field (wr_field),
    .wr_val   (wr_val)
  );

endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sec_tick,
  input logic      hold,
  input logic      busy,
  input logic      commit,
  input logic      done,
  input logic      time_wr,
  input rtc_time_t time_q
);

  a_r2_flag_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !hold && !busy) |=> busy);

  a_r2_commit_inside: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  a_r4_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold) |=> !busy);

  a_r3_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> done);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> $stable(time_q));

  a_r5_moves_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !time_wr) |=> $stable(time_q));

endmodule

bind rtc_timekeeper rtc_timekeeper_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sec_tick(sec_tick),
  .hold   (set_hold),
  .busy   (upd_busy),
  .commit (upd_commit),
  .done   (upd_done),
  .time_wr(time_wr),
  .time_q (time_q)
);

// File: tb/tb_rtc_timekeeper.sv
module tb_rtc_timekeeper;
  localparam int LEAD = 2;
  localparam int TAIL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       win_strobe = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       upd_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  rtc_timekeeper #(.LEAD_STROBES(LEAD), .TAIL_STROBES(TAIL)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .win_strobe(win_strobe),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .upd_done(upd_done));

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  int m_sec, m_min, m_hr, m_dow, m_dom, m_mon, m_yr, m_ctrl;
  int m_ph, m_cnt, m_done;

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic int enc(int v, int bin);
    return bin ? v : ((v / 10) * 16 + v % 10) & 255;
  endfunction

  function automatic int dec(int d, int bin);
    return bin ? (d & 127) : (d >> 4) * 10 + (d & 15);
  endfunction

  function automatic int m_read(int a);
    int bin, h;
    bin = (m_ctrl >> 2) & 1;
    case (a)
      0: return enc(m_sec, bin);
      2: return enc(m_min, bin);
      4: begin
        if ((m_ctrl >> 1) & 1) return enc(m_hr, bin);
        h = m_hr % 12;
        if (h == 0) h = 12;
        return enc(h, bin) | ((m_hr >= 12) ? 128 : 0);
      end
      6: return enc(m_dow, bin);
      7: return enc(m_dom, bin);
      8: return enc(m_mon, bin);
      9: return enc(m_yr, bin);
      10: return (m_ph != 0) ? 128 : 0;
      11: return m_ctrl;
      13: return 128;
      default: return 0;
    endcase
  endfunction

  task automatic m_write(int a, int d);
    int bin, v;
    bin = (m_ctrl >> 2) & 1;
    case (a)
      0: m_sec = dec(d, bin) & 63;
      2: m_min = dec(d, bin) & 63;
      4: begin
        if ((m_ctrl >> 1) & 1) m_hr = dec(d, bin) & 31;
        else begin
          v = dec(d & 127, bin);
          if (v == 12) v = 0;
          if (d & 128) v += 12;
          m_hr = v & 31;
        end
      end
      6: m_dow = dec(d, bin) & 7;
      7: m_dom = dec(d, bin) & 31;
      8: m_mon = dec(d, bin) & 15;
      9: m_yr  = dec(d, bin) & 127;
      default: ;
    endcase
  endtask

  task automatic m_advance();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
    m_dom++;
    if (m_dom <= dim(m_mon, m_yr)) return;
    m_dom = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1;
    m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0;
      m_ctrl = 2; m_ph = 0; m_cnt = 0; m_done = 0;
    end else begin
      int was_busy, dn;
      was_busy = (m_ph != 0);
      dn = (m_ph == 2);
      if (m_ph == 2) begin
        m_advance(); m_ph = 3; m_cnt = 0;
      end else if (m_ph == 1) begin
        if (win_strobe) begin m_cnt++; if (m_cnt == LEAD) m_ph = 2; end
      end else if (m_ph == 3) begin
        if (win_strobe) begin m_cnt++; if (m_cnt == TAIL) m_ph = 0; end
      end else if (sec_tick && !((m_ctrl >> 7) & 1)) begin
        m_ph = 1; m_cnt = 0;
      end
      if (bus_we) begin
        if (bus_addr == 4'd11) m_ctrl = bus_wdata;
        else if (!was_busy) m_write(bus_addr, bus_wdata);
      end
      m_done = dn;
    end
  end

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(int a);
    case (a)
      10: return "R2";
      11: return "R4";
      4:  return "R9";
      6:  return "R12";
      7, 8: return "R6";
      9:  return "R7";
      0, 2: return "R5";
      default: return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(int'(bus_rdata) == m_read(bus_addr), tag_for(bus_addr),
            bus_rdata, m_read(bus_addr));
      check(int'(upd_done) == m_done, "R3 upd_done", upd_done, m_done);
    end
  end

  // strobe source: one strobe every 5 cycles
  initial begin
    int sc = 0;
    forever begin
      @(posedge clk); #2;
      win_strobe = (sc % 5 == 4);
      sc++;
    end
  end

  // ---------------- stimulus (tasks run from posedge+2) ----------------
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(int a, int d);
    bus_we = 1; bus_addr = a[3:0]; bus_wdata = d[7:0];
    step();
    bus_we = 0;
  endtask

  task automatic rd_expect(int a, int exp, string tag);
    bus_addr = a[3:0];
    @(negedge clk);
    check(int'(bus_rdata) == exp, tag, bus_rdata, exp);
    step();
  endtask

  task automatic do_tick(int exp_pulses);
    int pulses = 0;
    bus_addr = 4'd10;
    sec_tick = 1;
    step();
    sec_tick = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (upd_done) pulses++;
      step();
      if (m_ph == 0 && i > 2) break;
    end
    check(pulses == exp_pulses, "R3 pulse count", pulses, exp_pulses);
  endtask

  task automatic set_time(int hr, int mn, int sc, int dow, int dom, int mon, int yr);
    wr(4, hr); wr(2, mn); wr(0, sc); wr(6, dow); wr(7, dom); wr(8, mon); wr(9, yr);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    step();

    // R1 reset state
    rd_expect(0, 0, "R1 sec"); rd_expect(2, 0, "R1 min"); rd_expect(4, 0, "R1 hr");
    rd_expect(6, 1, "R1 dow"); rd_expect(7, 1, "R1 dom"); rd_expect(8, 1, "R1 mon");
    rd_expect(9, 0, "R1 yr");  rd_expect(11, 8'h02, "R1 ctrl"); rd_expect(10, 0, "R1 stat");

    // R11 fixed and unused locations
    rd_expect(13, 8'h80, "R11 valid"); rd_expect(12, 0, "R11 unused12");
    rd_expect(15, 0, "R11 unused15"); rd_expect(1, 0, "R11 unused1");

    // R10 read-only locations
    wr(10, 8'hFF); rd_expect(10, 0, "R10 stat write");
    wr(13, 8'h00); rd_expect(13, 8'h80, "R10 valid write");

    // R4 hold blocks updates
    wr(11, 8'h82);
    set_time(8'h23, 8'h59, 8'h58, 7, 8'h28, 2, 8'h23);
    do_tick(0);
    rd_expect(0, 8'h58, "R4 held sec");
    wr(11, 8'h02);

    // R2/R5 one second
    bus_addr = 4'd10; sec_tick = 1; step(); sec_tick = 0;
    @(negedge clk); check(bus_rdata == 8'h80, "R2 flag up", bus_rdata, 8'h80); step();
    for (int i = 0; i < 200 && m_ph != 0; i++) step();
    rd_expect(0, 8'h59, "R5 sec");

    // R5/R12/R6 day carry, Feb non-leap
    do_tick(1);
    rd_expect(0, 0, "R5 sec wrap"); rd_expect(2, 0, "R5 min wrap"); rd_expect(4, 0, "R5 hr wrap");
    rd_expect(6, 1, "R12 dow wrap"); rd_expect(7, 1, "R6 feb28"); rd_expect(8, 3, "R6 to mar");

    // R6 leap February
    set_time(8'h23, 8'h59, 8'h59, 2, 8'h28, 2, 8'h24);
    do_tick(1);
    rd_expect(7, 8'h29, "R6 leap 29"); rd_expect(8, 2, "R6 leap mon"); rd_expect(6, 3, "R12 dow inc");
    set_time(8'h23, 8'h59, 8'h59, 3, 8'h29, 2, 8'h24);
    do_tick(1);
    rd_expect(7, 1, "R6 leap wrap"); rd_expect(8, 3, "R6 leap mar");

    // R6 30-day month
    set_time(8'h23, 8'h59, 8'h59, 4, 8'h30, 4, 8'h25);
    do_tick(1);
    rd_expect(7, 1, "R6 apr30"); rd_expect(8, 5, "R6 may");

    // R7 year end and year wrap
    set_time(8'h23, 8'h59, 8'h59, 5, 8'h31, 8'h12, 8'h99);
    do_tick(1);
    rd_expect(9, 0, "R7 yr wrap"); rd_expect(8, 1, "R7 mon wrap"); rd_expect(7, 1, "R7 dom");

    // R9 12-hour mode, BCD
    wr(11, 8'h00);
    set_time(8'h11, 8'h59, 8'h59, 1, 8'h10, 8'h06, 8'h30);
    rd_expect(4, 8'h11, "R9 11am");
    do_tick(1);
    rd_expect(4, 8'h92, "R9 12pm");
    wr(4, 8'h12); rd_expect(4, 8'h12, "R9 12am");
    wr(11, 8'h02); rd_expect(4, 8'h00, "R9 12am as 0");
    wr(11, 8'h00); wr(4, 8'h81);
    wr(11, 8'h02); rd_expect(4, 8'h13, "R9 1pm as 13");

    // R8 binary format
    wr(11, 8'h06); rd_expect(4, 8'h0D, "R8 hr bin");
    wr(2, 45); rd_expect(2, 45, "R8 min bin");
    wr(11, 8'h02); rd_expect(2, 8'h45, "R8 min bcd");

    // R10 writes during update are dropped
    wr(0, 8'h10);
    bus_addr = 4'd10; sec_tick = 1; step(); sec_tick = 0;
    wr(0, 8'h30);
    for (int i = 0; i < 200 && m_ph != 0; i++) step();
    rd_expect(0, 8'h11, "R10 busy write");

    // R2 tick while busy is dropped
    bus_addr = 4'd10; sec_tick = 1; step();
    repeat (3) step();
    sec_tick = 0;
    for (int i = 0; i < 200 && m_ph != 0; i++) step();
    rd_expect(0, 8'h12, "R2 extra tick ignored");

    repeat (3) step();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule